// File: doc/BRIEF.md
# Interrupt Aggregator with Fast-Line Steering

This block gathers single-cycle event pulses from thirteen peripheral sources into one pending register and pairs it with an enable mask. Software reads the pending flags at one register address. Writing ones to that same address clears the matching flags. The enabled pending flags are then merged onto eight request lines. Several sources share each line, and every line has a fixed vector address. When more than one line is raised, the block presents the vector of the lowest-numbered active line.

A three-bit select register takes one source group away from its normal request line and drives it onto a separate fast interrupt output. Only one group can be chosen at a time. The select code 7 routes nothing. The register port is a plain single-cycle write strobe with a 2-bit address. Read data is combinational from the same address. All outputs come from registered state and follow it one clock edge after an event or a write.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: While rst_n is low, and in the cycle after it goes high, the pending and enable registers read 0 and the select register reads 7 (none). All request lines, the fast interrupt output, the request flag and the vector output are 0.
- R2: A 1 on event bit i sets pending bit i. The flag stays set until it is cleared, whether or not the source is enabled. Bit 2 is not a source: it never sets and always reads 0. Pending flags are read at register address 1.
- R3: A write to address 1 clears each pending bit whose data bit is 1 and leaves the other bits unchanged. If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R4: Address 0 holds the 14-bit enable mask, which is written and read at that address. Enable bit 2 always reads 0. Address 3 reads 0, and writes to it change nothing.
- R5: Request line n is the OR of the pending-and-enabled bits in its group. The groups are: line 2 takes bits 11 and 10; line 3 takes bits 13 and 8; line 5 takes bits 12 and 9; line 6 takes bits 6, 5 and 4; line 7 takes bits 7, 3, 1 and 0. Lines 0, 1 and 4 have no sources here and stay 0.
- R6: Address 2 holds the fast select code in bits 2:0, and the bits above it read 0. The fast output is the OR of the enabled pending bits in the selected group. The codes are: 2 selects bit 11, 3 selects bit 10, 4 selects bit 8, 5 selects bits 12 and 9, and 6 selects bit 13. Codes 0, 1 and 7 select no source here.
- R7: While a group is selected for the fast output, its bits do not contribute to their request line. The other members of the same line still do.
- R8: The request flag is 1 when any request line is 1. When it is 1, the vector output is 0xFFF8 plus the index of the lowest-numbered active line. When no line is active, the vector output is 0x0000.
- R9: An event or register write sampled at a clock edge becomes visible on every output after that edge, and no earlier. With no event and no clear, the pending flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 14 | Event pulses, one bit per source (bit 2 unused) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 enable, 1 pending/clear, 2 fast select, 3 none |
| reg_wdata | input | 14 | Register write data |
| reg_rdata | output | 14 | Read data for reg_addr |
| irq_o | output | 8 | Request line levels |
| fiq_o | output | 1 | Fast interrupt level |
| irq_any_o | output | 1 | Any request line active |
| irq_vec_o | output | 16 | Vector address of the highest-priority active line |

## Verification
A wrong pending or enable bit shows up on the request lines, on the vector and on the read data one edge after the event or write that caused it. The bench therefore compares every output against its own model in every cycle. A group that is wrongly steered shows up in the same cycle as both the fast output and the request line it should have left, so each select code is tried while its whole line is pending. Clear-and-event collisions and the priority between lines are driven on purpose. A priority fault changes only the vector, not the line levels.

// File: rtl/irq_fiq_pkg.sv
package irq_fiq_pkg;
  localparam int NSRC  = 14;
  localparam int NLINE = 8;
  localparam int SELW  = 3;
  localparam logic [15:0] VEC_BASE = 16'hFFF8;

  localparam logic [1:0] ADDR_EN   = 2'd0;
  localparam logic [1:0] ADDR_PEND = 2'd1;
  localparam logic [1:0] ADDR_FSEL = 2'd2;

  localparam logic [SELW-1:0] FSEL_NONE = 3'd7;

  // Source position 2 carries no event.
  function automatic logic src_valid(input int b);
    return (b != 2) && (b >= 0) && (b < NSRC);
  endfunction

  // Request line that a source feeds.
  function automatic logic [2:0] src_line(input int b);
    case (b)
      13, 8:   return 3'd3;
      12, 9:   return 3'd5;
      11, 10:  return 3'd2;
      6, 5, 4: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  // Sources that a fast select code steals.
  function automatic logic [NSRC-1:0] fsel_group(input logic [SELW-1:0] sel);
    logic [NSRC-1:0] m;
    m = '0;
    case (sel)
      3'd2: m[11] = 1'b1;
      3'd3: m[10] = 1'b1;
      3'd4: m[8]  = 1'b1;
      3'd5: begin m[12] = 1'b1; m[9] = 1'b1; end
      3'd6: m[13] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [15:0] line_vector(input logic [2:0] n);
    return VEC_BASE + {13'd0, n};
  endfunction
endpackage

// File: rtl/irq_fiq_regs.sv
module irq_fiq_regs
  import irq_fiq_pkg::*;
#(
  parameter int N = NSRC,
  parameter int SW = SELW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  pend_q,
  output logic [N-1:0]  en_q,
  output logic [SW-1:0] sel_q,
  output logic [N-1:0]  rdata
);
  logic [N-1:0] valid_m;
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_valid
    assign valid_m[i] = src_valid(i);
  end

  assign set_vec = evt_i & valid_m;
  assign clr_vec = (reg_we && reg_addr == ADDR_PEND) ? reg_wdata : '0;
  assign pend_d  = (pend_q & ~clr_vec) | set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      sel_q  <= FSEL_NONE;
    end else begin
      pend_q <= pend_d;
      if (reg_we && reg_addr == ADDR_EN)   en_q  <= reg_wdata & valid_m;
      if (reg_we && reg_addr == ADDR_FSEL) sel_q <= reg_wdata[SW-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_EN:   rdata = en_q;
      ADDR_PEND: rdata = pend_q;
      ADDR_FSEL: rdata = {{(N-SW){1'b0}}, sel_q};
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_fiq_router.sv
module irq_fiq_router
  import irq_fiq_pkg::*;
#(
  parameter int N = NSRC,
  parameter int L = NLINE,
  parameter int SW = SELW
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  en,
  input  logic [SW-1:0] sel,
  output logic [L-1:0]  lines,
  output logic          fiq,
  output logic [N-1:0]  act_irq,
  output logic [N-1:0]  act_fiq
);
  logic [N-1:0] live;
  logic [N-1:0] steal;
  logic [N-1:0] member [L];

  assign live    = pend & en;
  assign steal   = fsel_group(sel);
  assign act_fiq = live & steal;
  assign act_irq = live & ~steal;
  assign fiq     = |act_fiq;

  for (genvar l = 0; l < L; l++) begin : g_line
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign member[l][i] = src_valid(i) && (src_line(i) == 3'(l));
    end
    assign lines[l] = |(act_irq & member[l]);
  end
endmodule

// File: rtl/irq_fiq_prio.sv
module irq_fiq_prio
  import irq_fiq_pkg::*;
#(
  parameter int L = NLINE
) (
  input  logic [L-1:0] lines,
  output logic         any,
  output logic [15:0]  vec
);
  assign any = |lines;

  always_comb begin
    vec = 16'h0000;
    for (int k = L - 1; k >= 0; k--) begin
      if (lines[k]) vec = line_vector(3'(k));
    end
  end
endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
  import irq_fiq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [NSRC-1:0]   reg_wdata,
  output logic [NSRC-1:0]   reg_rdata,
  output logic [NLINE-1:0]  irq_o,
  output logic              fiq_o,
  output logic              irq_any_o,
  output logic [15:0]       irq_vec_o
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] en_q;
  logic [SELW-1:0] sel_q;
  logic [NSRC-1:0] act_irq;
  logic [NSRC-1:0] act_fiq;

  irq_fiq_regs #(.N(NSRC), .SW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pend_q(pend_q), .en_q(en_q), .sel_q(sel_q), .rdata(reg_rdata)
  );

  irq_fiq_router #(.N(NSRC), .L(NLINE), .SW(SELW)) u_route (
    .pend(pend_q), .en(en_q), .sel(sel_q),
    .lines(irq_o), .fiq(fiq_o), .act_irq(act_irq), .act_fiq(act_fiq)
  );

  irq_fiq_prio #(.L(NLINE)) u_prio (
    .lines(irq_o), .any(irq_any_o), .vec(irq_vec_o)
  );
endmodule

// File: rtl/irq_fiq_ctrl_chk.sv
module irq_fiq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [13:0] evt_i,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [13:0] reg_wdata,
  input logic [7:0]  irq_o,
  input logic        fiq_o,
  input logic        irq_any_o,
  input logic [15:0] irq_vec_o,
  input logic [13:0] pend_q,
  input logic [13:0] en_q,
  input logic [2:0]  sel_q,
  input logic [13:0] act_irq,
  input logic [13:0] act_fiq
);
  localparam logic [13:0] SRC_M = 14'h3FFB;

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pend_q == 14'd0 && en_q == 14'd0 && sel_q == 3'd7));

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & SRC_M) != 14'd0) |=>
      ((pend_q & $past(evt_i & SRC_M)) == $past(evt_i & SRC_M)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd1) |=>
      ((pend_q & $past(reg_wdata & ~evt_i)) == 14'd0));

  p_line_needs_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != 8'd0) |-> ((pend_q & en_q) != 14'd0));

  p_fiq_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (sel_q >= 3'd2 && sel_q <= 3'd6 && act_fiq != 14'd0));

  p_steal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == 3'd2 && !(pend_q[10] && en_q[10])) |-> !irq_o[2]);

  p_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_irq & act_fiq) == 14'd0);

  p_vec_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any_o |-> (irq_o[irq_vec_o[2:0]] && irq_vec_o[15:3] == 13'h1FFF &&
      ((irq_o & ((8'd1 << irq_vec_o[2:0]) - 8'd1)) == 8'd0)));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_any_o |-> (irq_o == 8'd0 && irq_vec_o == 16'h0000));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i == 14'd0) && !(reg_we && reg_addr == 2'd1)) |=> $stable(pend_q));
endmodule

bind irq_fiq_ctrl irq_fiq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_o(irq_o),
  .fiq_o(fiq_o), .irq_any_o(irq_any_o), .irq_vec_o(irq_vec_o),
  .pend_q(pend_q), .en_q(en_q), .sel_q(sel_q),
  .act_irq(act_irq), .act_fiq(act_fiq)
);

// File: tb/tb_irq_fiq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_fiq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] evt_i = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [13:0] reg_wdata = '0;
  logic [13:0] reg_rdata;
  logic [7:0]  irq_o;
  logic        fiq_o;
  logic        irq_any_o;
  logic [15:0] irq_vec_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [13:0] m_pend = '0;
  logic [13:0] m_en   = '0;
  logic [2:0]  m_sel  = 3'd7;

  always #5 clk = ~clk;

  irq_fiq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .irq_any_o(irq_any_o), .irq_vec_o(irq_vec_o)
  );

  function automatic logic [13:0] stolen(input logic [2:0] s);
    case (s)
      3'd2: return 14'b10_0000_0000_0000 >> 2;  // bit 11
      3'd3: return 14'h0400;
      3'd4: return 14'h0100;
      3'd5: return 14'h1200;
      3'd6: return 14'h2000;
      default: return 14'h0000;
    endcase
  endfunction

  function automatic logic [7:0] exp_lines(input logic [13:0] p, input logic [13:0] e, input logic [2:0] s);
    logic [13:0] a;
    logic [7:0] r;
    a = p & e & ~stolen(s);
    r = '0;
    r[2] = a[11] | a[10];
    r[3] = a[13] | a[8];
    r[5] = a[12] | a[9];
    r[6] = a[6] | a[5] | a[4];
    r[7] = a[7] | a[3] | a[1] | a[0];
    return r;
  endfunction

  function automatic logic [15:0] exp_vec(input logic [7:0] ln);
    for (int k = 0; k < 8; k++)
      if (ln[k]) return 16'hFFF8 + 16'(k);
    return 16'h0000;
  endfunction

  function automatic logic [13:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_en;
      2'd1: return m_pend;
      2'd2: return {11'd0, m_sel};
      default: return 14'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    logic [7:0] ln;
    ln = exp_lines(m_pend, m_en, m_sel);
    chk({tag, " R5 R7 lines"}, 32'(irq_o), 32'(ln));
    chk({tag, " R6 fiq"}, 32'(fiq_o), 32'(|(m_pend & m_en & stolen(m_sel))));
    chk({tag, " R8 any"}, 32'(irq_any_o), 32'(|ln));
    chk({tag, " R8 vec"}, 32'(irq_vec_o), 32'(exp_vec(ln)));
    chk({tag, " R2 R4 rdata"}, 32'(reg_rdata), 32'(exp_rd(reg_addr)));
  endtask

  // Called at a falling edge: drives one cycle of stimulus, returns at the next falling edge.
  task automatic step(input logic [13:0] e, input logic we, input logic [1:0] a, input logic [13:0] d);
    logic [13:0] np, ne;
    logic [2:0]  ns;
    evt_i = e; reg_we = we; reg_addr = a; reg_wdata = d;
    np = (m_pend & ~((we && a == 2'd1) ? d : 14'd0)) | e;
    np[2] = 1'b0;
    ne = (we && a == 2'd0) ? d : m_en;
    ne[2] = 1'b0;
    ns = (we && a == 2'd2) ? d[2:0] : m_sel;
    @(posedge clk);
    @(negedge clk);
    m_pend = np; m_en = ne; m_sel = ns;
    evt_i = '0; reg_we = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1: reset values, both during reset and right after release
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 vec", 32'(irq_vec_o), 0);
    chk("R1 fiq", 32'(fiq_o), 0);
    reg_addr = 2'd2;
    #1 chk("R1 sel reads none", 32'(reg_rdata), 32'd7);
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 2'd1; #1 chk("R1 pend after release", 32'(reg_rdata), 0);
    reg_addr = 2'd0; #1 chk("R1 en after release", 32'(reg_rdata), 0);

    // R2: masked events still latch; bit 2 never sets
    step(14'h0804, 1'b0, 2'd1, 14'd0);
    chk("R2 pend latched while masked", 32'(reg_rdata), 32'h0800);
    chk("R2 R9 no line while masked", 32'(irq_o), 0);
    // R4: enable write, bit 2 dropped
    step(14'd0, 1'b1, 2'd0, 14'h3FFF);
    chk("R4 enable readback", 32'(reg_rdata), 32'h3FFB);
    check_all("R9 after enable");
    // R4: address 3 writes ignored
    step(14'd0, 1'b1, 2'd3, 14'h3FFF);
    chk("R4 addr3 reads 0", 32'(reg_rdata), 0);
    reg_addr = 2'd0; #1 chk("R4 enable unchanged by addr3", 32'(reg_rdata), 32'h3FFB);

    // R3: clear collides with new event on same bit
    step(14'h0001, 1'b0, 2'd1, 14'd0);
    step(14'h0800, 1'b1, 2'd1, 14'h0801);
    chk("R3 event beats clear", 32'(reg_rdata), 32'h0800);
    step(14'd0, 1'b1, 2'd1, 14'h0001);
    chk("R3 zeros leave bits", 32'(reg_rdata), 32'h0800);
    step(14'd0, 1'b1, 2'd1, 14'h3FFF);
    chk("R3 full clear", 32'(reg_rdata), 0);
    check_all("R3 idle");

    // R8: priority among lines 3, 5, 7
    step(14'h1201 | 14'h2000, 1'b0, 2'd1, 14'd0);
    chk("R8 lowest line vector", 32'(irq_vec_o), 32'hFFFB);
    check_all("R8 multi");

    // R6 R7: every select code with both timer bits and the other groups pending
    step(14'h3FFB, 1'b0, 2'd2, 14'd0);
    for (int s = 0; s < 8; s++) begin
      step(14'd0, 1'b1, 2'd2, 14'(s));
      check_all($sformatf("R6 R7 sel %0d", s));
    end
    step(14'd0, 1'b1, 2'd1, 14'h3FFF);

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      logic [13:0] e, d;
      logic we;
      logic [1:0] a;
      e  = 14'($urandom & $urandom & $urandom);
      we = ($urandom % 4) == 0;
      a  = 2'($urandom);
      d  = (a == 2'd1) ? 14'($urandom | $urandom) : 14'($urandom);
      step(e, we, a, d);
      check_all("rand R9");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule